// File: doc/BRIEF.md
# Serial Time-Code Pulse Width Classifier

This block receives a DC-level serial time-code line and reports what each pulse on it means. Every pulse on that line stands for one symbol, and the symbol is carried by how long the line stays high. The input is first brought into the local clock domain. Its rising and falling edges are then detected. A saturating counter measures how many clock cycles the line is high between a rising edge and the next falling edge.

When the falling edge is seen, the measured width is compared against three wide acceptance windows. The windows sit around nominal high times of 2 ms, 5 ms and 8 ms, and they are wide enough to absorb delay and clock inaccuracy. A width that falls in a window produces a symbol code and a one-cycle valid strobe. A width that falls in no window produces a one-cycle error strobe and no symbol. Frame alignment, symbol storage and decoding of the time fields belong to the blocks downstream of this one.

The clock rate is set by the parameter `CLKS_PER_MS`, the number of clock cycles in one millisecond. Written C below, it sets the windows: zero for C ≤ w < 3.5C, one for 3.5C ≤ w < 6.5C, marker for 6.5C ≤ w < 9.5C. The products 3.5C, 6.5C and 9.5C are each rounded down to a whole number of cycles.

Top module: `tcode_width_classifier`

## Requirements
- R1: While reset is active and after it is released with the input held low, `sym_valid` and `width_err` are 0 and `sym_code` is 0.
- R2: The measured width w is the number of consecutive rising clock edges at which the input is sampled high. A pulse of 3.5C−1 cycles and one of 3.5C cycles therefore fall on opposite sides of that boundary.
- R3: A pulse with C ≤ w < 3.5C produces `sym_valid` with `sym_code` = 0 (zero bit).
- R4: A pulse with 3.5C ≤ w < 6.5C produces `sym_valid` with `sym_code` = 1 (one bit).
- R5: A pulse with 6.5C ≤ w < 9.5C produces `sym_valid` with `sym_code` = 3 (position marker).
- R6: A pulse with w < C or w ≥ 9.5C produces a one-cycle `width_err` and no `sym_valid`.
- R7: `sym_valid` and `width_err` are single-cycle strobes that are never high together. Each is issued on the third rising clock edge counted from the edge that first samples the input low after a pulse. That edge is the first of the three.
- R8: The internal width counter saturates instead of wrapping. A pulse longer than the counter range is therefore still reported as an error and never aliases into a valid window.
- R9: No strobe is issued at a rising edge or while the input holds its level, and `sym_code` changes only together with `sym_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_in | input | 1 | Raw serial time-code level, asynchronous to `clk` |
| sym_code | output | 4 | Last classified symbol: 0 zero, 1 one, 3 marker |
| sym_valid | output | 1 | One-cycle strobe: `sym_code` holds a new symbol |
| width_err | output | 1 | One-cycle strobe: the last pulse matched no window |

## Verification
A pulse's result appears on the third rising edge counted from the edge that first samples `code_in` low. That is two synchronizer stages plus the output register. The bench's reference model notes the edge where it sees the line drop and schedules the expected strobe two edges after it. The model compares the outputs half a period after every edge, so every cycle is checked for both the presence and the absence of a strobe. The pulse widths are placed on each side of each window boundary, and one pulse is long enough to overrun the counter.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef logic [3:0] sym_t;

  localparam sym_t SYM_ZERO   = 4'd0;
  localparam sym_t SYM_ONE    = 4'd1;
  localparam sym_t SYM_MARKER = 4'd3;

  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_ONE    = 2'd1,
    CLS_MARKER = 2'd2,
    CLS_BAD    = 2'd3
  } cls_e;

  function automatic sym_t cls_to_sym(input cls_e c);
    case (c)
      CLS_ONE:    return SYM_ONE;
      CLS_MARKER: return SYM_MARKER;
      default:    return SYM_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/tcw_reset_sync.sv
module tcw_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tcw_edge_timer.sv
module tcw_edge_timer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_in,
  output logic             fall_stb,
  output logic [CNT_W-1:0] width
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       cnt_d;
  logic                   level;
  logic                   rise;

  assign level    = sync_q[SYNC_STAGES-1];
  assign rise     = level & ~prev_q;
  assign fall_stb = ~level & prev_q;
  assign width    = cnt_q;

  // Width counter: restart at a rising edge, count while high, hold at max.
  always_comb begin
    cnt_d = cnt_q;
    if (rise)
      cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (level && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], code_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= code_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= level;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/tcw_classifier.sv
module tcw_classifier
  import tcw_pkg::*;
#(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned LIM_LO = 20,
  parameter int unsigned LIM_01 = 70,
  parameter int unsigned LIM_1M = 130,
  parameter int unsigned LIM_HI = 190
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_stb,
  input  logic [CNT_W-1:0] width,
  output sym_t             sym_code,
  output logic             sym_valid,
  output logic             width_err
);

  localparam logic [CNT_W-1:0] B_LO = CNT_W'(LIM_LO);
  localparam logic [CNT_W-1:0] B_01 = CNT_W'(LIM_01);
  localparam logic [CNT_W-1:0] B_1M = CNT_W'(LIM_1M);
  localparam logic [CNT_W-1:0] B_HI = CNT_W'(LIM_HI);

  cls_e cls;
  sym_t sym_d;
  logic valid_d;
  logic err_d;

  always_comb begin
    if (width < B_LO)      cls = CLS_BAD;
    else if (width < B_01) cls = CLS_ZERO;
    else if (width < B_1M) cls = CLS_ONE;
    else if (width < B_HI) cls = CLS_MARKER;
    else                   cls = CLS_BAD;
  end

  always_comb begin
    valid_d = fall_stb && (cls != CLS_BAD);
    err_d   = fall_stb && (cls == CLS_BAD);
    sym_d   = valid_d ? cls_to_sym(cls) : sym_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_code  <= SYM_ZERO;
      sym_valid <= 1'b0;
      width_err <= 1'b0;
    end else begin
      sym_code  <= sym_d;
      sym_valid <= valid_d;
      width_err <= err_d;
    end
  end

endmodule

// File: rtl/tcode_width_classifier.sv
module tcode_width_classifier #(
  parameter int unsigned CLKS_PER_MS = 50000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       code_in,
  output logic [3:0] sym_code,
  output logic       sym_valid,
  output logic       width_err
);

  localparam int unsigned LIM_LO = CLKS_PER_MS;
  localparam int unsigned LIM_01 = (7  * CLKS_PER_MS) / 2;
  localparam int unsigned LIM_1M = (13 * CLKS_PER_MS) / 2;
  localparam int unsigned LIM_HI = (19 * CLKS_PER_MS) / 2;
  localparam int unsigned CNT_W  = $clog2(LIM_HI + 1) + 1;

  logic             rst_core_n;
  logic             fall_stb;
  logic [CNT_W-1:0] pulse_width;

  tcw_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  tcw_edge_timer #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .code_in  (code_in),
    .fall_stb (fall_stb),
    .width    (pulse_width)
  );

  tcw_classifier #(
    .CNT_W  (CNT_W),
    .LIM_LO (LIM_LO),
    .LIM_01 (LIM_01),
    .LIM_1M (LIM_1M),
    .LIM_HI (LIM_HI)
  ) u_cls (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fall_stb  (fall_stb),
    .width     (pulse_width),
    .sym_code  (sym_code),
    .sym_valid (sym_valid),
    .width_err (width_err)
  );

endmodule

// File: rtl/tcw_checker.sv
module tcw_checker #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       sym_code,
  input logic             sym_valid,
  input logic             width_err,
  input logic [CNT_W-1:0] pulse_width
);

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_valid && width_err)); // R7

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid); // R7

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |=> !width_err); // R6

  AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (sym_code == 4'd0 || sym_code == 4'd1 || sym_code == 4'd3)); // R5

  AST_SYM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> $stable(sym_code)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pulse_width) == {CNT_W{1'b1}}) |-> (pulse_width == {CNT_W{1'b1}} || pulse_width == {{(CNT_W-1){1'b0}}, 1'b1})); // R8

endmodule

bind tcode_width_classifier tcw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_code    (sym_code),
  .sym_valid   (sym_valid),
  .width_err   (width_err),
  .pulse_width (pulse_width)
);

// File: tb/tb_tcode_width_classifier.sv
module tb_tcode_width_classifier;

  localparam int C = 20;
  localparam int B_LO = C;
  localparam int B_01 = (7 * C) / 2;
  localparam int B_1M = (13 * C) / 2;
  localparam int B_HI = (19 * C) / 2;

  logic       clk;
  logic       rst_n;
  logic       code_in;
  logic [3:0] sym_code;
  logic       sym_valid;
  logic       width_err;

  int checks;
  int failures;
  int edge_n;
  int run_len;
  bit prev_raw;
  bit done;
  string cur_tag;
  int due_q[$];
  int kind_q[$];   // 0 zero, 1 one, 3 marker, -1 error
  string tag_q[$];

  tcode_width_classifier #(.CLKS_PER_MS(C)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_in   (code_in),
    .sym_code  (sym_code),
    .sym_valid (sym_valid),
    .width_err (width_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int classify(input int w);
    if (w < B_LO) return -1;
    if (w < B_01) return 0;
    if (w < B_1M) return 1;
    if (w < B_HI) return 3;
    return -1;
  endfunction

  // Reference model: samples the line at every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      edge_n = 0; run_len = 0; prev_raw = 1'b0;
    end else begin
      edge_n = edge_n + 1;
      if (code_in) begin
        run_len = prev_raw ? run_len + 1 : 1;
      end else if (prev_raw) begin
        due_q.push_back(edge_n + 2);
        kind_q.push_back(classify(run_len));
        tag_q.push_back(cur_tag);
      end
      prev_raw = code_in;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, half a period after the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (due_q.size() > 0 && due_q[0] == edge_n) begin
        int k;
        string t;
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        void'(due_q.pop_front());
        if (k < 0) begin
          check(width_err == 1'b1 && sym_valid == 1'b0, t, "err strobe", {sym_valid, width_err}, 1);
        end else begin
          check(sym_valid == 1'b1 && width_err == 1'b0, t, "valid strobe", {sym_valid, width_err}, 2);
          check(sym_code == 4'(k), t, "sym_code", sym_code, k);
        end
      end else begin
        check(sym_valid == 1'b0 && width_err == 1'b0, "R9", "idle strobes", {sym_valid, width_err}, 0);
      end
      check(!(sym_valid && width_err), "R7", "both strobes", {sym_valid, width_err}, 0);
    end
  end

  task automatic pulse(input int w, input string tag);
    cur_tag = tag;
    @(negedge clk); code_in = 1'b1;
    repeat (w) @(negedge clk);
    code_in = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    cur_tag = "R9";
    code_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sym_valid == 0 && width_err == 0 && sym_code == 0, "R1", "in reset", {sym_code, sym_valid, width_err}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sym_valid == 0 && width_err == 0 && sym_code == 0, "R1", "after reset", {sym_code, sym_valid, width_err}, 0);

    pulse(B_LO, "R3");
    pulse(2 * C, "R3");
    pulse(B_01 - 1, "R2");
    pulse(B_01, "R2");
    pulse(5 * C, "R4");
    pulse(B_1M - 1, "R4");
    pulse(B_1M, "R5");
    pulse(8 * C, "R5");
    pulse(B_HI - 1, "R5");
    pulse(B_HI, "R6");
    pulse(B_LO - 1, "R6");
    pulse(1, "R6");
    pulse(2 * C, "R3");
    pulse(1024 + 2 * C, "R8");
    pulse(5 * C, "R4");
    pulse(B_LO + 3, "R7");

    repeat (10) @(negedge clk);
    check(due_q.size() == 0, "R7", "pending events", due_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule